// File: doc/BRIEF.md
# Dual-Mode Baud Rate Generator

This block is a 16-bit down-counter with a programmable reload value, built to pace a serial receiver and transmitter. Software loads the reload value one byte at a time through a high-byte and a low-byte register port. While the receiver is enabled, each pass of the counter through zero gives a one-cycle bit-rate tick. The counter then restarts from the reload value.

While the receiver is off, the same counter can run as a free periodic timer. Setting the live-view control bit makes it raise a receive-interrupt request each time it reaches zero. The same control bit also picks the source for register reads: the programmed reload value, or the running count. The two bytes of a running count are read separately. Reading one byte captures nothing, so software that needs a consistent 16-bit snapshot has to handle byte rollover itself.

Top module: `baud_timer_gen`

## Requirements
- R1: After reset the reload value is 0. A write with `wr_hi`=0 sets reload bits [7:0] and a write with `wr_hi`=1 sets bits [15:8]. With `live_ctl`=0, `rd_data` shows reload bits [15:8] when `rd_hi`=1 and bits [7:0] when `rd_hi`=0, whether or not the counter is running.
- R2: With `live_ctl`=1, `rd_data` shows the byte of the running count that `rd_hi` selects, and the value is visible in the same cycle.
- R3: With `rx_en`=1, let N be the effective reload value. `baud_tick` is high for exactly one cycle, N cycles after the cycle in which the enable is applied, and then again every N+1 cycles.
- R4: With `rx_en`=0 and `live_ctl`=1, `timer_irq` pulses on the same schedule as in R3, and `baud_tick` stays low.
- R5: With `rx_en`=1, `timer_irq` is never asserted, whatever the value of `live_ctl`.
- R6: With `rx_en`=0 and `live_ctl`=0, both outputs stay low and the count is held at the effective reload value. After disabling, a new enable starts the count again from the reload value.
- R7: A reload value of 0 behaves as 1, so ticks repeat every 2 cycles and the counter never stalls.
- R8: A reload write made while the counter is running leaves the current count alone and takes effect at the next reload.
- R9: Reading the high byte does not latch the low byte. A high-byte read and a low-byte read in successive cycles of a running count can come from different count values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Reload byte write strobe |
| wr_hi | input | 1 | Write byte select: 1 = high byte, 0 = low byte |
| wr_data | input | 8 | Write data |
| rd_hi | input | 1 | Read byte select: 1 = high byte, 0 = low byte |
| live_ctl | input | 1 | 1 = reads show the live count and timer mode is enabled when the receiver is off |
| rx_en | input | 1 | Receiver enable; selects bit-rate tick mode |
| rd_data | output | 8 | Read data |
| baud_tick | output | 1 | One-cycle bit-rate tick |
| timer_irq | output | 1 | One-cycle timer interrupt request |

## Verification
Read data is combinational from the reload register or the count register, so it is sampled one time step after `rd_hi` is changed within a cycle. With reload N, an enable applied at a falling edge lets the count reach zero after N rising edges. Ticks and interrupts are therefore due at the Nth following falling edge and then every N+1 falling edges. Each scenario task counts falling edges from the enable and compares every cycle's output against that formula. A reload write is registered on the first rising edge after it is driven, so the changed period appears only after the next zero crossing, and the expected tick positions in the checks account for this.

// File: rtl/baud_timer_gen_pkg.sv
package baud_timer_gen_pkg;

    typedef enum logic [1:0] {
        RUN_IDLE  = 2'd0,
        RUN_BAUD  = 2'd1,
        RUN_TIMER = 2'd2
    } run_mode_e;

    typedef enum logic {
        LANE_LO = 1'b0,
        LANE_HI = 1'b1
    } lane_sel_e;

    function automatic run_mode_e pick_mode(input logic rx_on, input logic live);
        if (rx_on)
            return RUN_BAUD;
        else if (live)
            return RUN_TIMER;
        else
            return RUN_IDLE;
    endfunction

endpackage

// File: rtl/btg_reload_reg.sv
module btg_reload_reg
    import baud_timer_gen_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int LANES  = 2,
    localparam int CNT_W = BYTE_W * LANES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  lane_sel_e         wr_lane,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [CNT_W-1:0]  reload_q
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst)
                reload_q[g*BYTE_W +: BYTE_W] <= '0;
            else if (wr_en && (int'(wr_lane) == g))
                reload_q[g*BYTE_W +: BYTE_W] <= wr_data;
        end
    end

endmodule

// File: rtl/btg_counter.sv
module btg_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] cnt_q,
    output logic             at_zero
);

    logic [CNT_W-1:0] eff_reload;

    assign eff_reload = (reload == '0) ? CNT_W'(1) : reload;
    assign at_zero    = run && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (!run || cnt_q == '0)
            cnt_q <= eff_reload;
        else
            cnt_q <= cnt_q - CNT_W'(1);
    end

endmodule

// File: rtl/btg_readback.sv
module btg_readback
    import baud_timer_gen_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int LANES  = 2,
    localparam int CNT_W = BYTE_W * LANES
) (
    input  logic              live,
    input  lane_sel_e         rd_lane,
    input  logic [CNT_W-1:0]  reload,
    input  logic [CNT_W-1:0]  count,
    output logic [BYTE_W-1:0] rd_data
);

    logic [CNT_W-1:0] src;

    assign src = live ? count : reload;

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < LANES; i++)
            if (int'(rd_lane) == i)
                rd_data = src[i*BYTE_W +: BYTE_W];
    end

endmodule

// File: rtl/baud_timer_gen.sv
module baud_timer_gen
    import baud_timer_gen_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              rd_hi,
    input  logic              live_ctl,
    input  logic              rx_en,
    output logic [BYTE_W-1:0] rd_data,
    output logic              baud_tick,
    output logic              timer_irq
);

    localparam int LANES = 2;
    localparam int CNT_W = BYTE_W * LANES;

    run_mode_e        mode;
    logic [CNT_W-1:0] reload_q;
    logic [CNT_W-1:0] cnt_q;
    logic             at_zero;
    lane_sel_e        wr_lane;
    lane_sel_e        rd_lane;

    assign mode    = pick_mode(rx_en, live_ctl);
    assign wr_lane = wr_hi ? LANE_HI : LANE_LO;
    assign rd_lane = rd_hi ? LANE_HI : LANE_LO;

    btg_reload_reg #(.BYTE_W(BYTE_W), .LANES(LANES)) u_reload (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_lane  (wr_lane),
        .wr_data  (wr_data),
        .reload_q (reload_q)
    );

    btg_counter #(.CNT_W(CNT_W)) u_count (
        .clk     (clk),
        .rst     (rst),
        .run     (mode != RUN_IDLE),
        .reload  (reload_q),
        .cnt_q   (cnt_q),
        .at_zero (at_zero)
    );

    btg_readback #(.BYTE_W(BYTE_W), .LANES(LANES)) u_read (
        .live    (live_ctl),
        .rd_lane (rd_lane),
        .reload  (reload_q),
        .count   (cnt_q),
        .rd_data (rd_data)
    );

    assign baud_tick = at_zero && (mode == RUN_BAUD);
    assign timer_irq = at_zero && (mode == RUN_TIMER);

endmodule

// File: rtl/baud_timer_gen_chk.sv
module baud_timer_gen_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             rx_en,
    input logic             live_ctl,
    input logic             baud_tick,
    input logic             timer_irq,
    input logic [CNT_W-1:0] reload_q,
    input logic [CNT_W-1:0] cnt_q
);

    // R3
    baud_tick_single_chk: assert property (@(posedge clk) disable iff (rst)
        baud_tick |=> !baud_tick);

    // R4
    timer_irq_single_chk: assert property (@(posedge clk) disable iff (rst)
        timer_irq |=> !timer_irq);

    // R5
    rx_blocks_irq_chk: assert property (@(posedge clk) disable iff (rst)
        rx_en |-> !timer_irq);

    // R6
    idle_holds_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        !(rx_en || live_ctl) |=> (cnt_q != '0));

    // R8
    reload_on_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (baud_tick || timer_irq) |=>
            cnt_q == (($past(reload_q) == '0) ? CNT_W'(1) : $past(reload_q)));

endmodule

bind baud_timer_gen baud_timer_gen_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .rx_en     (rx_en),
    .live_ctl  (live_ctl),
    .baud_tick (baud_tick),
    .timer_irq (timer_irq),
    .reload_q  (reload_q),
    .cnt_q     (cnt_q)
);

// File: tb/baud_timer_gen_test.sv
`timescale 1ns/1ps
module baud_timer_gen_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic       wr_hi = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_hi = 1'b0;
    logic       live_ctl = 1'b0;
    logic       rx_en = 1'b0;
    logic [7:0] rd_data;
    logic       baud_tick;
    logic       timer_irq;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;

    always #2.5 clk = ~clk;

    baud_timer_gen uut (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_hi     (wr_hi),
        .wr_data   (wr_data),
        .rd_hi     (rd_hi),
        .live_ctl  (live_ctl),
        .rx_en     (rx_en),
        .rd_data   (rd_data),
        .baud_tick (baud_tick),
        .timer_irq (timer_irq)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic read_byte(input bit hi, input string req, input int exp);
        rd_hi = hi;
        #1;
        check(rd_data == exp[7:0], req, rd_data, exp);
    endtask

    task automatic write_byte(input bit hi, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_hi = hi; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic go_idle();
        @(negedge clk);
        rx_en = 1'b0; live_ctl = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic load(input int val);
        write_byte(1'b1, val[15:8]);
        write_byte(1'b0, val[7:0]);
        go_idle();
    endtask

    // enable applied at a falling edge (k = 0); pulse due at k = n, then every n+1
    task automatic run_cadence(input int n, input bit timer_mode, input int cycles, input string req);
        for (int k = 1; k <= cycles; k++) begin
            bit due;
            @(negedge clk);
            due = (k >= n) && ((k - n) % (n + 1) == 0);
            check(baud_tick == (due && !timer_mode), req, baud_tick, due && !timer_mode);
            check(timer_irq == (due && timer_mode), req, timer_irq, due && timer_mode);
        end
    endtask

    task automatic t_reset();
        read_byte(1'b0, "R1 reset lo", 0);
        read_byte(1'b1, "R1 reset hi", 0);
        check(!baud_tick && !timer_irq, "R6 reset outputs", {baud_tick, timer_irq}, 0);
    endtask

    task automatic t_readback();
        load(16'h1234);
        read_byte(1'b1, "R1 reload hi", 8'h12);
        read_byte(1'b0, "R1 reload lo", 8'h34);
    endtask

    task automatic t_baud_and_restart();
        load(5);
        @(negedge clk); rx_en = 1'b1;
        run_cadence(5, 1'b0, 8, "R3 baud cadence");
        read_byte(1'b0, "R1 reload read while running", 5);
        go_idle();
        run_cadence(1000, 1'b0, 10, "R6 idle quiet");
        @(negedge clk); rx_en = 1'b1;
        run_cadence(5, 1'b0, 18, "R6 restart from reload");
        go_idle();
    endtask

    task automatic t_timer();
        load(3);
        @(negedge clk); live_ctl = 1'b1;
        run_cadence(3, 1'b1, 12, "R4 timer irq");
        go_idle();
        @(negedge clk); live_ctl = 1'b1; rx_en = 1'b1;
        run_cadence(3, 1'b0, 12, "R5 rx on, no irq");
        go_idle();
    endtask

    task automatic t_zero_reload();
        load(0);
        @(negedge clk); rx_en = 1'b1;
        run_cadence(1, 1'b0, 7, "R7 zero reload as one");
        go_idle();
    endtask

    task automatic t_midwrite();
        load(4);
        @(negedge clk); rx_en = 1'b1;
        for (int k = 1; k <= 16; k++) begin
            bit due;
            @(negedge clk);
            due = (k == 4) || (k == 14);
            check(baud_tick == due, "R8 write applies at reload", baud_tick, due);
            if (k == 2) begin wr_en = 1'b1; wr_hi = 1'b0; wr_data = 8'd9; end
            if (k == 3) wr_en = 1'b0;
        end
        go_idle();
    endtask

    task automatic t_live_read();
        load(16'h0100);
        @(negedge clk); rx_en = 1'b1; live_ctl = 1'b1;
        read_byte(1'b1, "R2 live hi at start", 8'h01);
        read_byte(1'b0, "R2 live lo at start", 8'h00);
        @(negedge clk);
        read_byte(1'b0, "R9 lo after rollover", 8'hFF);
        read_byte(1'b1, "R9 hi after rollover", 8'h00);
        @(negedge clk);
        read_byte(1'b0, "R2 live lo next", 8'hFE);
        live_ctl = 1'b0;
        read_byte(1'b1, "R1 reload hi with live off", 8'h01);
        go_idle();
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_readback();
        t_baud_and_restart();
        t_timer();
        t_zero_reload();
        t_midwrite();
        t_live_read();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule